// File: doc/BRIEF.md
# FIFO-Buffered SPI Master Controller

This block is a register-programmed serial master that moves a programmed number of frames over a four-wire serial bus. Software writes transmit words into a 32-entry queue and sets a frame count, a clock divider, a frame size and a clock mode. It then sets the enable bit. The engine pops one word per frame, shifts it out most-significant bit first, and pushes the word captured on the input line into a 32-entry receive queue. Software drains that queue through the same data address.

Two mechanisms tie the bus to the queues. In flow-controlled mode, the engine holds the serial clock at its idle level between frames while the receive queue is full or, when transmitting, while the transmit queue is empty. It starts the next frame once room or data appears. Without flow control the engine never waits: a missing transmit word is replaced by zeros, and a frame that finds the receive queue full is discarded. A receive-only setting clocks the programmed frames with the output line held high and leaves the transmit queue untouched. Select lines are driven straight from a one-hot select register.

Top module: `spim_fifo_ctrl`

## Requirements
- R1: After reset the serial clock is low, all select outputs are inactive (high), status reads busy=0, tx_full=0, rx_empty=1, and the receive level reads 0. Register addresses: 0 enable (bit 0), 1 config, 2 frame count, 3 divider, 4 select, 5 data (write pushes transmit, read pops receive), 6 status (bit 0 busy, bit 1 tx_full, bit 2 rx_empty), 7 receive level.
- R2: The serial clock has a half period of DIV/2 input clocks, with DIV an even value from 2 to 65534 held in the low 16 bits of register 3. Each frame starts one half period before its first clock edge. Busy is therefore high for exactly 1 + N*(1 + W*DIV) cycles for N frames of W bits when nothing stalls.
- R3: Config bit 0 (CPOL) sets the idle clock level, and config bit 1 (CPHA) selects sampling on the leading edge (0) or the trailing edge (1), with the output changing on the other edge. Bits go out most-significant first.
- R4: Config bit 2 selects 16-bit frames (1) or 8-bit frames (0). An 8-bit frame uses only the low 8 bits of a transmit word, and the received word is zero-extended. A frame has 2*W clock edges.
- R5: Each completed frame pushes the captured input word into the receive queue. Register 7 reports the number of waiting words.
- R6: With config bit 3 (receive-only) set, the output line is held high for every frame and no transmit word is consumed.
- R7: With config bit 4 (flow control) set, the clock stops at its idle level between frames while the receive queue is full, or while the transmit queue is empty in transmit mode. The transfer resumes when the condition clears.
- R8: With config bit 4 clear, the transfer never stalls. An empty transmit queue yields an all-zero frame, and a frame completing with the receive queue full is dropped.
- R9: A transfer moves (count + 1) frames, where count is register 2 (16 bits). Writes to register 2 are ignored while enabled.
- R10: Writing 0 to enable while enabled stops the transfer at once, returns the clock to idle, clears busy and empties both queues.
- R11: After the last frame, busy falls and the clock stays quiet until the controller is disabled and enabled again.
- R12: Each bit of the select register drives one select output, active low. Writing zero releases all of them.
- R13: Status tx_full is 1 when 32 transmit words are waiting. rx_empty is 1 when no received word is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at address 5) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_sel | output | 4 | Select lines, active low |

## Verification
The in-design properties assume that software keeps the divider even and at least 2 whenever the controller is enabled, and that config is not rewritten during a transfer. The receive-only mosi check and the flow-control push check depend on config staying fixed. The bench therefore writes config, divider and count only while disabled, allows a few settling cycles, and then enables. It only ever writes even divisors. A bus monitor in the bench samples the output line on the edge that the programmed mode names as the sampling edge. The input line is looped back from the output, so every received word is predictable from the transmitted one.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
   localparam int unsigned ADDR_ENABLE = 0;
   localparam int unsigned ADDR_CONFIG = 1;
   localparam int unsigned ADDR_COUNT  = 2;
   localparam int unsigned ADDR_DIV    = 3;
   localparam int unsigned ADDR_SELECT = 4;
   localparam int unsigned ADDR_DATA   = 5;
   localparam int unsigned ADDR_STATUS = 6;
   localparam int unsigned ADDR_LEVEL  = 7;

   typedef enum logic [1:0] {
      ENG_IDLE = 2'd0,
      ENG_LOAD = 2'd1,
      ENG_RUN  = 2'd2,
      ENG_DONE = 2'd3
   } eng_state_t;

   typedef struct packed {
      logic managed;
      logic rx_only;
      logic wide;
      logic cpha;
      logic cpol;
   } spim_cfg_t;
endpackage

// File: rtl/spim_fifo.sv
`timescale 1ns/1ps
module spim_fifo #(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned DEPTH = 32,
   localparam int unsigned PW = $clog2(DEPTH),
   localparam int unsigned LW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             full,
   output logic             empty,
   output logic [LW-1:0]    level
);
   generate
      if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("spim_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wptr, rptr;
   logic [LW-1:0]    cnt;
   logic             do_push, do_pop;

   assign full    = (cnt == LW'(DEPTH));
   assign empty   = (cnt == '0);
   assign level   = cnt;
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign rdata   = mem[rptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else if (flush) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         if (do_push && !do_pop)      cnt <= cnt + 1'b1;
         else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= wdata;
   end

   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH)); // R13

   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> full); // R8
endmodule

// File: rtl/spim_regs.sv
`timescale 1ns/1ps
module spim_regs
   import spim_pkg::*;
#(
   parameter int unsigned DW     = 32,
   parameter int unsigned AW     = 3,
   parameter int unsigned FW     = 16,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DIV_W  = 16,
   parameter int unsigned NSEL   = 4,
   parameter int unsigned LW     = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [AW-1:0]    reg_addr,
   input  logic [DW-1:0]    reg_wdata,
   output logic [DW-1:0]    reg_rdata,
   output logic             en,
   output spim_cfg_t        cfg,
   output logic [CNT_W-1:0] count,
   output logic [DIV_W-1:0] div,
   output logic [NSEL-1:0]  sel,
   output logic             flush,
   output logic             tx_push,
   output logic [FW-1:0]    tx_wdata,
   output logic             rx_pop,
   input  logic [FW-1:0]    rx_head,
   input  logic             busy,
   input  logic             tx_full,
   input  logic             rx_empty,
   input  logic [LW-1:0]    rx_level
);
   localparam int unsigned CFG_W = $bits(spim_cfg_t);

   generate
      if (DW < FW || DW < CNT_W || DW < DIV_W || DW < NSEL || DW < LW || DW < CFG_W)
      begin : g_bad_dw
         $error("spim_regs: DW too narrow for a register field");
      end
      if (AW < 3) begin : g_bad_aw
         $error("spim_regs: AW must cover eight addresses");
      end
   endgenerate

   logic hit_en, hit_cfg, hit_cnt, hit_div, hit_sel, hit_dat;
   assign hit_en  = reg_wr && (reg_addr == AW'(ADDR_ENABLE));
   assign hit_cfg = reg_wr && (reg_addr == AW'(ADDR_CONFIG));
   assign hit_cnt = reg_wr && (reg_addr == AW'(ADDR_COUNT));
   assign hit_div = reg_wr && (reg_addr == AW'(ADDR_DIV));
   assign hit_sel = reg_wr && (reg_addr == AW'(ADDR_SELECT));
   assign hit_dat = reg_wr && (reg_addr == AW'(ADDR_DATA));

   assign flush    = hit_en && !reg_wdata[0] && en;
   assign tx_push  = hit_dat;
   assign tx_wdata = reg_wdata[FW-1:0];
   assign rx_pop   = reg_rd && (reg_addr == AW'(ADDR_DATA));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en    <= 1'b0;
         cfg   <= '0;
         count <= '0;
         div   <= DIV_W'(2);
         sel   <= '0;
      end else begin
         if (hit_en)            en    <= reg_wdata[0];
         if (hit_cfg)           cfg   <= spim_cfg_t'(reg_wdata[CFG_W-1:0]);
         if (hit_cnt && !en)    count <= reg_wdata[CNT_W-1:0];
         if (hit_div)           div   <= reg_wdata[DIV_W-1:0];
         if (hit_sel)           sel   <= reg_wdata[NSEL-1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         AW'(ADDR_ENABLE): reg_rdata[0]           = en;
         AW'(ADDR_CONFIG): reg_rdata[CFG_W-1:0]   = cfg;
         AW'(ADDR_COUNT):  reg_rdata[CNT_W-1:0]   = count;
         AW'(ADDR_DIV):    reg_rdata[DIV_W-1:0]   = div;
         AW'(ADDR_SELECT): reg_rdata[NSEL-1:0]    = sel;
         AW'(ADDR_DATA):   reg_rdata[FW-1:0]      = rx_head;
         AW'(ADDR_STATUS): reg_rdata[2:0]         = {rx_empty, tx_full, busy};
         AW'(ADDR_LEVEL):  reg_rdata[LW-1:0]      = rx_level;
         default:          reg_rdata              = '0;
      endcase
   end

   AST_COUNT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> $stable(count)); // R9
endmodule

// File: rtl/spim_engine.sv
`timescale 1ns/1ps
module spim_engine
   import spim_pkg::*;
#(
   parameter int unsigned FW    = 16,
   parameter int unsigned CNT_W = 16,
   parameter int unsigned DIV_W = 16,
   localparam int unsigned HW   = FW / 2,
   localparam int unsigned EW   = $clog2(2 * FW),
   localparam int unsigned HCW  = DIV_W - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  spim_cfg_t        cfg,
   input  logic [CNT_W-1:0] count,
   input  logic [DIV_W-1:0] div,
   input  logic             tx_empty,
   input  logic [FW-1:0]    tx_data,
   output logic             tx_pop,
   input  logic             rx_full,
   output logic             rx_push,
   output logic [FW-1:0]    rx_data,
   output logic             sclk,
   output logic             mosi,
   input  logic             miso,
   output logic             busy
);
   generate
      if (FW < 2 || (FW % 2) != 0) begin : g_bad_fw
         $error("spim_engine: FW must be even");
      end
      if (DIV_W < 2) begin : g_bad_divw
         $error("spim_engine: DIV_W must be at least 2");
      end
   endgenerate

   eng_state_t       state;
   logic [HCW-1:0]   hcnt, half;
   logic [EW-1:0]    edge_cnt, edge_last;
   logic [CNT_W-1:0] left;
   logic [FW-1:0]    txsr, rxsr, rx_next, rx_word, frame_raw, frame_al;
   logic             sclk_q, mosi_q;
   logic             can_load, tick, last_edge, lead_edge, sample_edge, change_edge;
   logic             unused_div_lsb;

   assign unused_div_lsb = div[0];
   assign half      = (div[DIV_W-1:1] == '0) ? HCW'(1) : div[DIV_W-1:1];
   assign edge_last = cfg.wide ? EW'(2 * FW - 1) : EW'(FW - 1);

   assign can_load  = cfg.rx_only ? (!cfg.managed || !rx_full)
                                  : (!cfg.managed || (!tx_empty && !rx_full));
   assign frame_raw = cfg.rx_only ? '1 : (tx_empty ? '0 : tx_data);
   assign frame_al  = cfg.wide ? frame_raw : {frame_raw[HW-1:0], {HW{1'b0}}};

   assign tick        = (state == ENG_RUN) && (hcnt == half - 1'b1);
   assign last_edge   = (edge_cnt == edge_last);
   assign lead_edge   = !edge_cnt[0];
   assign sample_edge = cfg.cpha ? !lead_edge : lead_edge;
   assign change_edge = !sample_edge;

   assign rx_next = {rxsr[FW-2:0], miso};
   assign rx_word = sample_edge ? rx_next : rxsr;
   assign rx_data = cfg.wide ? rx_word : {{HW{1'b0}}, rx_word[HW-1:0]};

   assign tx_pop  = (state == ENG_LOAD) && en && can_load && !cfg.rx_only && !tx_empty;
   assign rx_push = tick && en && last_edge;

   assign sclk = sclk_q;
   assign mosi = mosi_q;
   assign busy = en && (state != ENG_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ENG_IDLE;
         hcnt     <= '0;
         edge_cnt <= '0;
         left     <= '0;
         txsr     <= '0;
         rxsr     <= '0;
         sclk_q   <= 1'b0;
         mosi_q   <= 1'b0;
      end else if (!en) begin
         state    <= ENG_IDLE;
         hcnt     <= '0;
         edge_cnt <= '0;
         sclk_q   <= cfg.cpol;
      end else begin
         case (state)
            ENG_IDLE: begin
               left   <= count;
               sclk_q <= cfg.cpol;
               state  <= ENG_LOAD;
            end
            ENG_LOAD: begin
               if (can_load) begin
                  if (cfg.cpha) begin
                     txsr <= frame_al;
                     if (cfg.rx_only) mosi_q <= 1'b1;
                  end else begin
                     txsr   <= {frame_al[FW-2:0], 1'b0};
                     mosi_q <= frame_al[FW-1];
                  end
                  hcnt     <= '0;
                  edge_cnt <= '0;
                  state    <= ENG_RUN;
               end
            end
            ENG_RUN: begin
               if (tick) begin
                  hcnt     <= '0;
                  sclk_q   <= ~sclk_q;
                  edge_cnt <= edge_cnt + 1'b1;
                  if (change_edge) begin
                     mosi_q <= txsr[FW-1];
                     txsr   <= {txsr[FW-2:0], 1'b0};
                  end
                  if (sample_edge) rxsr <= rx_next;
                  if (last_edge) begin
                     if (left == '0) begin
                        state <= ENG_DONE;
                     end else begin
                        left  <= left - 1'b1;
                        state <= ENG_LOAD;
                     end
                  end
               end else begin
                  hcnt <= hcnt + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (!div[0] && (div >= DIV_W'(2)))); // R2

   AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && cfg.managed) |-> !rx_full); // R7

   AST_RXONLY_MOSI_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cfg.rx_only && (state == ENG_RUN)) |-> mosi); // R6

   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (state == ENG_DONE)) |=> (!en || $stable(sclk))); // R11
endmodule

// File: rtl/spim_fifo_ctrl.sv
`timescale 1ns/1ps
module spim_fifo_ctrl
   import spim_pkg::*;
#(
   parameter int unsigned DW        = 32,
   parameter int unsigned AW        = 3,
   parameter int unsigned FW        = 16,
   parameter int unsigned DEPTH     = 32,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned DIV_W     = 16,
   parameter int unsigned NSEL      = 4,
   parameter bit          SEL_ACT_HIGH = 1'b0,
   localparam int unsigned LW       = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_wr,
   input  logic            reg_rd,
   input  logic [AW-1:0]   reg_addr,
   input  logic [DW-1:0]   reg_wdata,
   output logic [DW-1:0]   reg_rdata,
   output logic            spi_sclk,
   output logic            spi_mosi,
   input  logic            spi_miso,
   output logic [NSEL-1:0] spi_sel
);
   logic             en, flush, busy;
   spim_cfg_t        cfg;
   logic [CNT_W-1:0] count;
   logic [DIV_W-1:0] div;
   logic [NSEL-1:0]  sel;
   logic             tx_push, tx_pop, tx_full, tx_empty;
   logic [FW-1:0]    tx_wdata, tx_head;
   logic             rx_push, rx_pop, rx_full, rx_empty;
   logic [FW-1:0]    rx_wdata, rx_head;
   logic [LW-1:0]    rx_level, tx_level;
   logic             unused_tx_level;

   assign unused_tx_level = ^tx_level;

   spim_regs #(.DW(DW), .AW(AW), .FW(FW), .CNT_W(CNT_W), .DIV_W(DIV_W),
               .NSEL(NSEL), .LW(LW)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .en(en), .cfg(cfg), .count(count), .div(div), .sel(sel), .flush(flush),
      .tx_push(tx_push), .tx_wdata(tx_wdata), .rx_pop(rx_pop), .rx_head(rx_head),
      .busy(busy), .tx_full(tx_full), .rx_empty(rx_empty), .rx_level(rx_level)
   );

   spim_fifo #(.WIDTH(FW), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(flush), .push(tx_push), .wdata(tx_wdata),
      .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty), .level(tx_level)
   );

   spim_fifo #(.WIDTH(FW), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(flush), .push(rx_push), .wdata(rx_wdata),
      .pop(rx_pop), .rdata(rx_head), .full(rx_full), .empty(rx_empty), .level(rx_level)
   );

   spim_engine #(.FW(FW), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .en(en), .cfg(cfg), .count(count), .div(div),
      .tx_empty(tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
      .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_wdata),
      .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso), .busy(busy)
   );

   generate
      for (genvar i = 0; i < NSEL; i++) begin : g_sel
         if (SEL_ACT_HIGH) begin : g_high
            assign spi_sel[i] = sel[i];
         end else begin : g_low
            assign spi_sel[i] = ~sel[i];
         end
      end
   endgenerate

   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (rx_empty && !tx_full && !busy)); // R10
endmodule

// File: tb/tb_spim_fifo_ctrl.sv
`timescale 1ns/1ps
module tb_spim_fifo_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        spi_sclk, spi_mosi;
   logic [3:0]  spi_sel;

   int total = 0, bad = 0;

   spim_fifo_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_mosi),
      .spi_sel(spi_sel)
   );

   always #4 clk = ~clk;

   // bus monitor: samples mosi on the edge the mode defines as sampling edge
   logic        mcpol = 1'b0, mcpha = 1'b0;
   int          edges = 0;
   logic [15:0] cap = '0;
   always @(posedge spi_sclk or negedge spi_sclk) begin
      edges = edges + 1;
      if ((spi_sclk != mcpol) ^ mcpha) cap = {cap[14:0], spi_mosi};
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      reg_rd = (a == 5); reg_addr = 3'(a);
      #1 d = int'(reg_rdata);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wait_idle(output int cyc);
      reg_addr = 3'd6;
      cyc = 0;
      #1;
      while (reg_rdata[0] && cyc < 100000) begin
         cyc++;
         @(negedge clk);
         #1;
      end
   endtask

   task automatic setup(input int cpol, input int cpha, input int wide,
                        input int rxo, input int man, input int dv, input int cnt);
      wr(1, (man << 4) | (rxo << 3) | (wide << 2) | (cpha << 1) | cpol);
      wr(3, dv);
      wr(2, cnt);
      repeat (3) @(negedge clk);
      mcpol = cpol[0]; mcpha = cpha[0];
      edges = 0; cap = '0;
   endtask

   // {cpol, cpha, wide, div[7:0], data[15:0]}
   localparam logic [26:0] VEC [8] = '{
      {1'b0, 1'b0, 1'b0, 8'd2, 16'h12A5},
      {1'b0, 1'b1, 1'b0, 8'd4, 16'h003C},
      {1'b1, 1'b0, 1'b0, 8'd6, 16'h0081},
      {1'b1, 1'b1, 1'b0, 8'd2, 16'hFF7E},
      {1'b0, 1'b0, 1'b1, 8'd2, 16'hBEEF},
      {1'b1, 1'b1, 1'b1, 8'd4, 16'h1234},
      {1'b0, 1'b1, 1'b1, 8'd8, 16'hF00D},
      {1'b1, 1'b0, 1'b1, 8'd2, 16'h8001}
   };

   initial begin
      #(8 * 190000);
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int d, cyc, e0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 sclk", int'(spi_sclk), 0);
      chk("R1 sel", int'(spi_sel), 4'hF);
      rd(6, d); chk("R1 status", d, 32'h4);
      rd(7, d); chk("R1 level", d, 0);

      // R12 select lines
      wr(4, 4'b0100); @(negedge clk); chk("R12 one", int'(spi_sel), 4'b1011);
      wr(4, 0);       @(negedge clk); chk("R12 release", int'(spi_sel), 4'hF);

      // table walk: R2 R3 R4 R5
      for (int i = 0; i < 8; i++) begin
         logic [26:0] v;
         int w, exp;
         v = VEC[i];
         w = v[24] ? 16 : 8;
         exp = v[24] ? int'(v[15:0]) : int'(v[7:0]);
         setup(int'(v[26]), int'(v[25]), int'(v[24]), 0, 1, int'(v[23:16]), 0);
         wr(5, int'(v[15:0]));
         wr(0, 1);
         wait_idle(cyc);
         chk("R2 busy cycles", cyc, 2 + w * int'(v[23:16]));
         chk("R4 edges", edges, 2 * w);
         chk("R3 captured", v[24] ? int'(cap) : int'(cap[7:0]), exp);
         chk("R3 idle level", int'(spi_sclk), int'(v[26]));
         rd(7, d); chk("R5 level", d, 1);
         rd(5, d); chk("R5 data", d, exp);
         wr(0, 0);
      end

      // R9 multi-frame, count lock; R11 quiet after done
      setup(0, 0, 0, 0, 1, 2, 2);
      wr(5, 8'h11); wr(5, 8'h22); wr(5, 8'h33);
      wr(0, 1);
      wait_idle(cyc);
      chk("R9 three frames cycles", cyc, 1 + 3 * 17);
      chk("R9 edges", edges, 48);
      wr(2, 7);
      rd(2, d); chk("R9 count locked", d, 2);
      e0 = edges;
      repeat (20) @(negedge clk);
      chk("R11 quiet edges", edges, e0);
      rd(6, d); chk("R11 busy low", d & 1, 0);
      rd(5, d); chk("R5 first", d, 8'h11);
      rd(5, d); chk("R5 second", d, 8'h22);
      rd(5, d); chk("R5 third", d, 8'h33);
      wr(0, 0);

      // R6 receive-only
      setup(0, 1, 0, 1, 1, 2, 3);
      wr(0, 1);
      wait_idle(cyc);
      chk("R6 cycles", cyc, 1 + 4 * 17);
      chk("R6 mosi pattern", int'(cap[7:0]), 8'hFF);
      rd(7, d); chk("R6 level", d, 4);
      rd(5, d); chk("R6 data", d, 8'hFF);
      wr(0, 0);

      // R7 receive-full stall
      setup(0, 0, 0, 1, 1, 2, 32);
      wr(0, 1);
      reg_addr = 3'd7; cyc = 0; #1;
      while (reg_rdata != 32 && cyc < 5000) begin cyc++; @(negedge clk); #1; end
      repeat (10) @(negedge clk);
      e0 = edges;
      repeat (40) @(negedge clk);
      chk("R7 clock stopped", edges, e0);
      rd(6, d); chk("R7 busy while stalled", d & 1, 1);
      chk("R7 idle level", int'(spi_sclk), 0);
      rd(5, d);
      wait_idle(cyc);
      rd(7, d); chk("R7 resumed level", d, 32);
      wr(0, 0);

      // R8 no stall on full receive queue
      setup(0, 0, 0, 1, 0, 2, 32);
      wr(0, 1);
      wait_idle(cyc);
      chk("R8 no stall cycles", cyc, 1 + 33 * 17);
      rd(7, d); chk("R8 drop level", d, 32);
      wr(0, 0);

      // R7 transmit-empty stall
      setup(0, 0, 0, 0, 1, 2, 1);
      wr(5, 8'h5A);
      wr(0, 1);
      repeat (40) @(negedge clk);
      chk("R7 tx stall edges", edges, 16);
      rd(6, d); chk("R7 tx stall busy", d & 1, 1);
      wr(5, 8'hC3);
      wait_idle(cyc);
      rd(5, d); chk("R7 word one", d, 8'h5A);
      rd(5, d); chk("R7 word two", d, 8'hC3);
      wr(0, 0);

      // R8 zero frame on empty transmit queue
      setup(0, 0, 0, 0, 0, 2, 1);
      wr(5, 8'h5A);
      wr(0, 1);
      wait_idle(cyc);
      chk("R8 underflow cycles", cyc, 1 + 2 * 17);
      rd(5, d); chk("R8 word one", d, 8'h5A);
      rd(5, d); chk("R8 zero word", d, 0);
      wr(0, 0);

      // R13 / R10 full flags and abort with flush
      setup(1, 0, 0, 1, 1, 2, 100);
      for (int k = 0; k < 32; k++) wr(5, k);
      rd(6, d); chk("R13 tx_full", (d >> 1) & 1, 1);
      wr(0, 1);
      reg_addr = 3'd7; cyc = 0; #1;
      while (reg_rdata != 32 && cyc < 5000) begin cyc++; @(negedge clk); #1; end
      rd(6, d); chk("R6 tx untouched", (d >> 1) & 1, 1);
      chk("R13 rx not empty", (d >> 2) & 1, 0);
      wr(0, 0);
      @(negedge clk);
      rd(6, d); chk("R10 status after abort", d, 32'h4);
      rd(7, d); chk("R10 level flushed", d, 0);
      chk("R10 clock idle", int'(spi_sclk), 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule